// File: doc/BRIEF.md
# Dual Machine-Cycle Timer/Counter

This block holds two independent 16-bit counting channels behind a small byte-wide register port. Each channel advances either once per machine cycle (one machine cycle is twelve input clock periods) or once per falling edge seen on its own external pulse pin. The pin is sampled once per machine cycle. A shared configuration byte selects, for each channel, the clock source, an optional gate, and one of four counting shapes:

- a 13-bit counter
- a full 16-bit counter
- an 8-bit counter that reloads itself from the high byte
- a hold setting

When a channel rolls over, it raises a request flag for an interrupt controller. The controller clears the flag with a one-cycle acknowledge.

In typical use, software stops a channel and writes the count bytes so that a rollover happens after the wanted number of steps. It then sets the channel's run bit. In 16-bit use, the interrupt handler writes the start value again. For example, a start value of 3CB0h gives 50,000 steps before rollover.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every register reads 00h and both `irq_req` bits are low.
- R2: Register map for both writes and reads:
  - address 0: configuration byte
  - address 1: control; bit0 runs channel 0, bit1 runs channel 1, bit4 and bit5 read back the two request flags
  - addresses 2 and 3: channel 0 low and high byte
  - addresses 4 and 5: channel 1 low and high byte
  
  A written count byte reads back from the next cycle on, even while the channel runs. A write wins over a step in the same cycle.
- R3: A running channel in internal mode takes exactly one step in every 12 consecutive clock cycles.
- R4: A channel whose run bit is clear, or whose mode field is 3, keeps its count unchanged.
- R5: Configuration nibble layout: channel 0 uses bits 3:0 and channel 1 uses bits 7:4. Within a nibble, bit3 is the gate, bit2 selects the external pin, and bits 1:0 give the mode. With the gate bit set, a channel steps only while its `gate_pin` is high.
- R6: With the external select bit set, a 1-to-0 change of `ext_pin` between two machine-cycle samples gives exactly one step.
- R7: In mode 1, the 16-bit count wraps from FFFFh to 0000h and sets that channel's request flag.
- R8: In mode 0, the count is the high byte joined with the low 5 bits of the low byte. It wraps from all ones to zero and sets the flag. Low-byte bits 7:5 keep their value.
- R9: In mode 2, the low byte steps and, on passing FFh, takes the high byte's value and sets the flag. Flags are therefore (256 − high byte) × 12 clock cycles apart.
- R10: An `irq_ack` pulse clears the matching flag in the next cycle, unless a rollover sets it in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the oscillator |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ext_pin | input | 2 | External count pulse pin per channel |
| gate_pin | input | 2 | External gate level per channel |
| irq_ack | input | 2 | Request acknowledge per channel |
| irq_req | output | 2 | Rollover request flag per channel |

## Verification
The hardest behaviour to observe from the ports is the exact cadence of the prescaler. The phase of the machine cycle is hidden, so a single read cannot show whether steps come every 12 clocks. The bench therefore takes two reads a fixed number of clocks apart while the channel runs, and checks the difference. It also times the gap between two consecutive rollovers in the self-reloading mode, which must come out to exactly (256 − reload) × 12 cycles. Rollover values are caught by polling the request flag every cycle; the count cannot move again for another eleven clocks after the flag rises.

// File: rtl/tmr_pkg.sv
// Package tmr_pkg: shared types and constants for the dual timer/counter.
// Assumes a byte-wide register port and two channels per configuration byte.
package tmr_pkg;
    localparam int BYTE_W   = 8;
    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 3;
    localparam int N_CH     = 2;
    localparam int LOW13_W  = 5;
    localparam int WIDE13_W = BYTE_W + LOW13_W;
    localparam int WIDE16_W = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;

    typedef enum logic [1:0] {
        MODE_13   = 2'd0,
        MODE_16   = 2'd1,
        MODE_8REL = 2'd2,
        MODE_HOLD = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic      gate;
        logic      ext_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;
endpackage

// File: rtl/tmr_prescale.sv
// Module tmr_prescale: divides the clock into a one-cycle machine-cycle strobe.
// Assumes DIV >= 2; the strobe is high for one clock in every DIV clocks.
module tmr_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Free-running phase counter, wraps after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Strobe on the last phase of each machine cycle.
    always_comb tick = (phase_q == LAST);
endmodule

// File: rtl/tmr_pin_sampler.sv
// Module tmr_pin_sampler: synchronises the count and gate pins and finds
// falling edges between two machine-cycle samples.
// Assumes SYNC >= 2; pins are asynchronous to clk.
module tmr_pin_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  logic gate_pin,
    output logic fall,
    output logic gate_s
);
    logic [SYNC-1:0] pin_sh;
    logic [SYNC-1:0] gate_sh;
    logic            sample_q;

    // Synchroniser chains for both pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sh  <= '0;
            gate_sh <= '0;
        end else begin
            pin_sh  <= {pin_sh[SYNC-2:0], pin};
            gate_sh <= {gate_sh[SYNC-2:0], gate_pin};
        end
    end

    // Machine-cycle sample of the count pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_q <= 1'b0;
        else if (tick)
            sample_q <= pin_sh[SYNC-1];
    end

    // A high sample followed by a low one is one count.
    always_comb begin
        fall   = tick && sample_q && !pin_sh[SYNC-1];
        gate_s = gate_sh[SYNC-1];
    end
endmodule

// File: rtl/tmr_channel.sv
// Module tmr_channel: one count register pair with its modes and request flag.
// Assumes tick and fall are single-cycle strobes; writes override steps.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fall,
    input  logic              gate_s,
    input  logic              run,
    input  tmr_cfg_t          cfg,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ack,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              flag_q
);
    logic              step;
    logic              wrap;
    logic [BYTE_W-1:0] lo_n;
    logic [BYTE_W-1:0] hi_n;

    // Step qualifier: run bit, optional gate, then clock source.
    always_comb step = run && (!cfg.gate || gate_s) && (cfg.ext_sel ? fall : tick);

    // Next count and rollover detection for the selected mode.
    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        wrap = 1'b0;
        case (cfg.mode)
            MODE_13: begin
                wrap = &{hi_q, lo_q[LOW13_W-1:0]};
                {hi_n, lo_n[LOW13_W-1:0]} = {hi_q, lo_q[LOW13_W-1:0]} + WIDE13_W'(1);
            end
            MODE_16: begin
                wrap = &{hi_q, lo_q};
                {hi_n, lo_n} = {hi_q, lo_q} + WIDE16_W'(1);
            end
            MODE_8REL: begin
                wrap = &lo_q;
                lo_n = wrap ? hi_q : lo_q + 1'b1;
            end
            default: begin
                wrap = 1'b0;
            end
        endcase
    end

    // Count registers: a byte write takes priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_lo)
                lo_q <= wdata;
            else if (step)
                lo_q <= lo_n;
            if (wr_hi)
                hi_q <= wdata;
            else if (step)
                hi_q <= hi_n;
        end
    end

    // Request flag: rollover sets it, acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (step && wrap)
            flag_q <= 1'b1;
        else if (ack)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/tmr_dual.sv
// Module tmr_dual: two timer/counter channels behind a byte register port.
// Assumes a single clock domain; rd_data is a combinational read.
module tmr_dual
    import tmr_pkg::*;
#(
    parameter int DIV  = 12,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [N_CH-1:0]   ext_pin,
    input  logic [N_CH-1:0]   gate_pin,
    input  logic [N_CH-1:0]   irq_ack,
    output logic [N_CH-1:0]   irq_req
);
    logic              tick;
    logic [BYTE_W-1:0] cfg_q;
    logic [N_CH-1:0]   run_q;
    logic [BYTE_W-1:0] cnt_lo [N_CH];
    logic [BYTE_W-1:0] cnt_hi [N_CH];

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    // Configuration and run-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_CFG)
                cfg_q <= wr_data;
            if (wr_addr == A_CTRL)
                run_q <= wr_data[N_CH-1:0];
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(A_CNT + 2 * i);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(A_CNT + 2 * i + 1);
        logic     fall;
        logic     gate_s;
        tmr_cfg_t cfg;

        // Slice this channel's nibble of the configuration byte.
        always_comb cfg = tmr_cfg_t'(cfg_q[NIB_W*i +: NIB_W]);

        tmr_pin_sampler #(.SYNC(SYNC)) u_pins (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .pin     (ext_pin[i]),
            .gate_pin(gate_pin[i]),
            .fall    (fall),
            .gate_s  (gate_s)
        );

        tmr_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .fall  (fall),
            .gate_s(gate_s),
            .run   (run_q[i]),
            .cfg   (cfg),
            .wr_lo (wr_en && wr_addr == A_LO),
            .wr_hi (wr_en && wr_addr == A_HI),
            .wdata (wr_data),
            .ack   (irq_ack[i]),
            .lo_q  (cnt_lo[i]),
            .hi_q  (cnt_hi[i]),
            .flag_q(irq_req[i])
        );
    end

    // Register read multiplexer.
    always_comb begin
        case (rd_addr)
            A_CFG:  rd_data = cfg_q;
            A_CTRL: rd_data = {2'b00, irq_req, 2'b00, run_q};
            3'd2:   rd_data = cnt_lo[0];
            3'd3:   rd_data = cnt_hi[0];
            3'd4:   rd_data = cnt_lo[1];
            3'd5:   rd_data = cnt_hi[1];
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tmr_dual_chk.sv
// Module tmr_dual_chk: temporal checks on the dual timer, bound into tmr_dual.
module tmr_dual_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        wr_en,
    input logic [7:0]  cfg,
    input logic [1:0]  run,
    input logic [1:0]  irq_ack,
    input logic [1:0]  irq_req,
    input logic [15:0] cnt0
);
    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req[0]) |-> $past(tick));

    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_ack[0]) && !$past(tick)) |-> !irq_req[0]);

    // R4
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run[0]) && !$past(wr_en)) |-> $stable(cnt0));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req[0]) && $past(cfg[1:0]) == 2'b01 && !$past(wr_en)) |-> cnt0 == 16'h0000);
endmodule

bind tmr_dual tmr_dual_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .wr_en  (wr_en),
    .cfg    (cfg_q),
    .run    (run_q),
    .irq_ack(irq_ack),
    .irq_req(irq_req),
    .cnt0   ({cnt_hi[0], cnt_lo[0]})
);

// File: tb/tmr_dual_test.sv
module tmr_dual_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] ext_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] irq_ack = 2'b00;
    logic [1:0] irq_req;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_dual uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_pin(ext_pin), .gate_pin(gate_pin), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic ack_all();
        @(negedge clk); irq_ack = 2'b11;
        @(negedge clk); irq_ack = 2'b00;
    endtask

    task automatic wait_flag(input int idx, output int n);
        n = 0;
        while (!irq_req[idx] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 register after reset", {8'h00, v}, 16'h0000);
        end
        check("R1 irq after reset", {14'd0, irq_req}, 16'h0000);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(3'd0, 8'h01); rd(3'd0, v); check("R2 config readback", {8'h00, v}, 16'h0001);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd1, 8'h01); rd(3'd1, v); check("R2 control readback", {8'h00, v}, 16'h0001);
        repeat (50) @(negedge clk);
        wr(3'd2, 8'hB0); rd(3'd2, v); check("R2 low write while running", {8'h00, v}, 16'h00B0);
        wr(3'd3, 8'h3C); rd(3'd3, v); check("R2 high write while running", {8'h00, v}, 16'h003C);
    endtask

    task automatic t_rate();
        logic [7:0] a, b;
        rd(3'd2, a);
        repeat (300) @(negedge clk);
        rd(3'd2, b);
        check("R3 steps in 300 clocks", {8'h00, 8'(b - a)}, 16'd25);
    endtask

    task automatic t_hold();
        logic [7:0] a, b, c;
        wr(3'd1, 8'h00); rd(3'd2, a);
        repeat (100) @(negedge clk);
        rd(3'd2, b);
        check("R4 stopped count holds", {8'h00, b}, {8'h00, a});
        wr(3'd0, 8'h03); wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd1, 8'h01);
        repeat (60) @(negedge clk);
        rd(3'd2, b); rd(3'd3, c);
        check("R4 mode 3 holds", {c, b}, 16'h1234);
    endtask

    task automatic t_gate();
        logic [7:0] a, b;
        wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        gate_pin[0] = 1'b0;
        wr(3'd1, 8'h01);
        repeat (120) @(negedge clk);
        rd(3'd2, a);
        check("R5 gate low blocks", {8'h00, a}, 16'h0000);
        gate_pin[0] = 1'b1;
        repeat (10) @(negedge clk);
        rd(3'd2, a);
        repeat (120) @(negedge clk);
        rd(3'd2, b);
        check("R5 gate high counts", {8'h00, 8'(b - a)}, 16'd10);
        gate_pin[0] = 1'b0;
    endtask

    task automatic t_counter();
        logic [7:0] a, b;
        wr(3'd1, 8'h00); wr(3'd0, 8'h51); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
        wr(3'd1, 8'h02);
        repeat (50) @(negedge clk);
        rd(3'd4, a);
        check("R6 no pulses no count", {8'h00, a}, 16'h0000);
        for (int p = 0; p < 5; p++) begin
            ext_pin[1] = 1'b0; repeat (48) @(negedge clk);
            ext_pin[1] = 1'b1; repeat (48) @(negedge clk);
        end
        rd(3'd4, a); rd(3'd5, b);
        check("R6 five falling edges", {b, a}, 16'h0005);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_wrap16();
        logic [7:0] a, b;
        int n;
        wr(3'd1, 8'h00); wr(3'd0, 8'h01); wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
        ack_all();
        wr(3'd1, 8'h01);
        wait_flag(0, n);
        check("R7 flag raised", {15'd0, irq_req[0]}, 16'h0001);
        rd(3'd2, a); rd(3'd3, b);
        check("R7 wraps to zero", {b, a}, 16'h0000);
        rd(3'd1, a);
        check("R7 flag in control", {8'h00, a & 8'h30}, 16'h0010);
        @(negedge clk); irq_ack[0] = 1'b1;
        @(negedge clk); irq_ack[0] = 1'b0;
        check("R10 ack clears flag", {15'd0, irq_req[0]}, 16'h0000);
    endtask

    task automatic t_wrap13();
        logic [7:0] a, b;
        int n;
        wr(3'd1, 8'h00); wr(3'd0, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        ack_all();
        wr(3'd1, 8'h01);
        wait_flag(0, n);
        rd(3'd2, a); rd(3'd3, b);
        check("R8 13-bit wrap keeps low bits 7:5", {b, a}, 16'h00E0);
        check("R8 flag raised", {15'd0, irq_req[0]}, 16'h0001);
    endtask

    task automatic t_reload();
        logic [7:0] a, b;
        int n, n2;
        wr(3'd1, 8'h00); wr(3'd0, 8'h02); wr(3'd2, 8'hF6); wr(3'd3, 8'hF6);
        ack_all();
        wr(3'd1, 8'h01);
        wait_flag(0, n);
        rd(3'd2, a); rd(3'd3, b);
        check("R9 reload value", {b, a}, 16'hF6F6);
        @(negedge clk); irq_ack[0] = 1'b1;
        @(negedge clk); irq_ack[0] = 1'b0;
        check("R10 ack clears reload flag", {15'd0, irq_req[0]}, 16'h0000);
        wait_flag(0, n2);
        check("R9 rollover period", 16'(n2 + 2), 16'd120);
        wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_rate();
        t_hold();
        t_gate();
        t_counter();
        t_wrap16();
        t_wrap13();
        t_reload();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule